// File: doc/BRIEF.md
# Level-Shifted Multicarrier PWM Generator

This block drives the four switch-pair commands of a five-level inverter phase leg. Four triangular carriers of equal amplitude and frequency are stacked into four adjacent amplitude bands with no gap and no overlap. The signed reference sample is compared against every carrier at once, and each comparison gives one gate bit. The boundary between the two inner bands is the zero of the reference.

All four carriers come from one shared up/down counter. The phase of each band is chosen by a mode input, and there are three arrangements. In the first, every band is in phase. In the second, the two upper bands are in phase and the two lower bands are inverted. In the third, the bands alternate, so each band is in opposite phase to its neighbours. A second output gives the signed phase level, from -2 to +2. The carrier half-period is programmable. A typical setting makes the carrier twenty times faster than the reference, for example 1 kHz against 50 Hz. Mode and period changes are applied only at a carrier-period boundary.

Top module: `mlpwm_top`

## Requirements
- R1: While rst_ni is low, gate_o is 0000 and level_o is -2. After release the counter starts at 0 and counts upward, the mode is in-phase and the half-period is the DEF_PER parameter (20).
- R2: The counter c follows 0,1,…,P,P-1,…,1,0,1,…, so one carrier period is 2P cycles. P is taken from period_i, and a period_i of 0 is treated as 1.
- R3: Band k (0 = bottom, 3 = top) has carrier (k-2)·P + v, where v is c for an in-phase band and P-c for an inverted band. The four bands therefore cover [-2P, 2P] without overlap.
- R4: gate_o[k] is registered and is 1 exactly when the signed ref_i is strictly greater than the band-k carrier. The carrier value and ref_i are both taken at the preceding clock edge, so the latency is one cycle.
- R5: mode_i = 0 (and the spare code 3) puts all bands in phase.
- R6: mode_i = 1 puts bands 2 and 3 in phase and inverts bands 0 and 1.
- R7: mode_i = 2 puts bands 0 and 2 in phase and inverts bands 1 and 3.
- R8: level_o is the number of set gate_o bits minus 2. It is a two's-complement value and changes on the same edge as gate_o.
- R9: mode_i and period_i are sampled only at the clock edge where the counter returns to 0. A change at any other time has no effect until then.
- R10: gate_o is always thermometer coded, so gate_o[k+1] = 1 implies gate_o[k] = 1. A ref_i above 2P gives 1111 and a ref_i at or below -2P gives 0000 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 12 | Signed reference sample, scaled to ±2P |
| mode_i | input | 2 | Carrier arrangement: 0 in-phase, 1 lower bands inverted, 2 alternating |
| period_i | input | 8 | Carrier half-period P in clock cycles |
| gate_o | output | 4 | Registered comparator bit per band, bit 0 = lowest band |
| level_o | output | 3 | Signed output level, -2 to +2 |

## Verification
Two things can land on the same clock edge: a mode or period request, and the counter's return to zero that loads it. In that case the new arrangement must apply from the very next carrier sample, while a request made one cycle earlier or later must not. The bench provokes this collision by toggling mode_i every few cycles over several carrier periods, and by changing period_i between very different values, including 0. Every cycle it compares gate_o and level_o against an independent cycle model of the counter, the bands and the one-cycle comparator latency.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;
  typedef enum logic [1:0] {
    MODE_PD   = 2'd0,
    MODE_POD  = 2'd1,
    MODE_APOD = 2'd2,
    MODE_SPR  = 2'd3
  } mode_e;

  // 1 when band k of n runs on the inverted triangle
  function automatic logic band_inv(mode_e m, int unsigned k, int unsigned n);
    case (m)
      MODE_POD:  return (k < n / 2);
      MODE_APOD: return k[0];
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mlpwm_carrier_cnt.sv
module mlpwm_carrier_cnt
  import mlpwm_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int DEF_PER = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic [1:0]       mode_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] per_o,
  output mode_e            mode_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n, per_q, per_ld;
  logic             up_q, up_n, wrap;
  mode_e            mode_q;

  always_comb begin
    if (up_q) begin
      if (cnt_q >= per_q) begin
        cnt_n = cnt_q - 1'b1;
        up_n  = 1'b0;
      end else begin
        cnt_n = cnt_q + 1'b1;
        up_n  = 1'b1;
      end
    end else begin
      cnt_n = cnt_q - 1'b1;
      up_n  = 1'b0;
    end
    wrap = (cnt_n == '0);
    if (wrap) up_n = 1'b1;
  end

  assign per_ld = (period_i == '0) ? CNT_W'(1) : period_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      up_q   <= 1'b1;
      per_q  <= CNT_W'(DEF_PER);
      mode_q <= MODE_PD;
    end else begin
      cnt_q <= cnt_n;
      up_q  <= up_n;
      // period boundary: new settings apply from the zero sample on
      if (wrap) begin
        per_q  <= per_ld;
        mode_q <= mode_e'(mode_i);
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign per_o  = per_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/mlpwm_carrier_bank.sv
module mlpwm_carrier_bank
  import mlpwm_pkg::*;
#(
  parameter int N_CARR = 4,
  parameter int CNT_W  = 8,
  parameter int CMP_W  = 13
) (
  input  logic [CNT_W-1:0]              cnt_i,
  input  logic [CNT_W-1:0]              per_i,
  input  mode_e                         mode_i,
  output logic [N_CARR-1:0][CMP_W-1:0]  car_o
);
  logic signed [CMP_W-1:0] per_s, cnt_s, acc;
  logic signed [CMP_W-1:0] base [N_CARR];

  assign per_s = $signed({{(CMP_W-CNT_W){1'b0}}, per_i});
  assign cnt_s = $signed({{(CMP_W-CNT_W){1'b0}}, cnt_i});

  // band floors: -(N/2)P, ..., (N/2-1)P
  always_comb begin
    acc = '0;
    for (int j = 0; j < N_CARR / 2; j++) acc = acc - per_s;
    for (int k = 0; k < N_CARR; k++) begin
      base[k] = acc;
      acc     = acc + per_s;
    end
  end

  for (genvar k = 0; k < N_CARR; k++) begin : g_band
    logic signed [CMP_W-1:0] ph;
    assign ph       = band_inv(mode_i, k, N_CARR) ? (per_s - cnt_s) : cnt_s;
    assign car_o[k] = base[k] + ph;
  end
endmodule

// File: rtl/mlpwm_cmp.sv
module mlpwm_cmp #(
  parameter int N_CARR = 4,
  parameter int REF_W  = 12,
  parameter int CMP_W  = 13,
  parameter int LVL_W  = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [REF_W-1:0]              ref_i,
  input  logic [N_CARR-1:0][CMP_W-1:0]  car_i,
  output logic [N_CARR-1:0]             gate_o,
  output logic [LVL_W-1:0]              level_o
);
  localparam logic [LVL_W-1:0] MID = LVL_W'(N_CARR / 2);

  logic signed [CMP_W-1:0] ref_s;
  logic [N_CARR-1:0]       gate_d, gate_q;
  logic [LVL_W-1:0]        ones, level_d, level_q;

  assign ref_s = $signed({{(CMP_W-REF_W){ref_i[REF_W-1]}}, ref_i});

  for (genvar k = 0; k < N_CARR; k++) begin : g_cmp
    assign gate_d[k] = ref_s > $signed(car_i[k]);
  end

  always_comb begin
    ones = '0;
    for (int k = 0; k < N_CARR; k++) ones = ones + LVL_W'(gate_d[k]);
    level_d = ones - MID;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q  <= '0;
      level_q <= '0 - MID;
    end else begin
      gate_q  <= gate_d;
      level_q <= level_d;
    end
  end

  assign gate_o  = gate_q;
  assign level_o = level_q;
endmodule

// File: rtl/mlpwm_top.sv
module mlpwm_top
  import mlpwm_pkg::*;
#(
  parameter int N_CARR  = 4,
  parameter int REF_W   = 12,
  parameter int CNT_W   = 8,
  parameter int DEF_PER = 20
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [REF_W-1:0]        ref_i,
  input  logic [1:0]              mode_i,
  input  logic [CNT_W-1:0]        period_i,
  output logic [N_CARR-1:0]       gate_o,
  output logic [$clog2(N_CARR/2+1):0] level_o
);
  localparam int CAR_W = CNT_W + $clog2(N_CARR / 2) + 2;
  localparam int CMP_W = ((REF_W > CAR_W) ? REF_W : CAR_W) + 1;
  localparam int LVL_W = $clog2(N_CARR / 2 + 1) + 1;

  logic [CNT_W-1:0]             cnt_q, per_q;
  mode_e                        mode_q;
  logic [N_CARR-1:0][CMP_W-1:0] car;

  mlpwm_carrier_cnt #(.CNT_W(CNT_W), .DEF_PER(DEF_PER)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .period_i (period_i),
    .mode_i   (mode_i),
    .cnt_o    (cnt_q),
    .per_o    (per_q),
    .mode_o   (mode_q)
  );

  mlpwm_carrier_bank #(.N_CARR(N_CARR), .CNT_W(CNT_W), .CMP_W(CMP_W)) u_bank (
    .cnt_i  (cnt_q),
    .per_i  (per_q),
    .mode_i (mode_q),
    .car_o  (car)
  );

  mlpwm_cmp #(.N_CARR(N_CARR), .REF_W(REF_W), .CMP_W(CMP_W), .LVL_W(LVL_W)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ref_i   (ref_i),
    .car_i   (car),
    .gate_o  (gate_o),
    .level_o (level_o)
  );
endmodule

// File: rtl/mlpwm_chk.sv
module mlpwm_chk #(
  parameter int N_CARR = 4,
  parameter int REF_W  = 12,
  parameter int CNT_W  = 8,
  parameter int LVL_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [REF_W-1:0]  ref_i,
  input logic [N_CARR-1:0] gate_i,
  input logic [LVL_W-1:0]  level_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  per_i,
  input logic [1:0]        mode_i
);
  logic seen_q, sat_hi, sat_lo;
  int   span;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  always_comb begin
    span   = int'(per_i) * (N_CARR / 2);
    sat_hi = int'($signed(ref_i)) > span;
    sat_lo = int'($signed(ref_i)) <= -span;
  end

  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= per_i);

  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> ((cnt_i == $past(cnt_i) + 1'b1) || ($past(cnt_i) == cnt_i + 1'b1)));

  assert_mode_at_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_i) |-> (cnt_i == '0));

  assert_per_at_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(per_i) |-> (cnt_i == '0));

  assert_level_sum_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'($signed(level_i)) == $countones(gate_i) - N_CARR / 2);

  assert_sat_hi_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_hi |=> (&gate_i));

  assert_sat_lo_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_lo |=> (gate_i == '0));

  for (genvar k = 0; k < N_CARR - 1; k++) begin : g_thermo
    assert_thermo_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gate_i[k+1] |-> gate_i[k]);
  end
endmodule

bind mlpwm_top mlpwm_chk #(
  .N_CARR (N_CARR),
  .REF_W  (REF_W),
  .CNT_W  (CNT_W),
  .LVL_W  (LVL_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ref_i   (ref_i),
  .gate_i  (gate_o),
  .level_i (level_o),
  .cnt_i   (cnt_q),
  .per_i   (per_q),
  .mode_i  (mode_q)
);

// File: tb/tb_mlpwm_top.sv
module tb_mlpwm_top;
  localparam int DEF = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] ref_i;
  logic [1:0]  mode_i;
  logic [7:0]  period_i;
  logic [3:0]  gate_o;
  logic [2:0]  level_o;

  int checks = 0;
  int errs   = 0;

  always #10 clk = ~clk;

  mlpwm_top dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .ref_i    (ref_i),
    .mode_i   (mode_i),
    .period_i (period_i),
    .gate_o   (gate_o),
    .level_o  (level_o)
  );

  // cycle model from the requirements
  int       m_cnt, m_per, m_mode, exp_lvl, r, car, ph, ones, nc;
  bit       m_up, inv;
  bit [3:0] exp_gate, g;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_up = 1; m_per = DEF; m_mode = 0;
      exp_gate = 4'b0000; exp_lvl = -2;
    end else begin
      r = int'($signed(ref_i));
      ones = 0;
      for (int k = 0; k < 4; k++) begin
        inv  = (m_mode == 1) ? (k < 2) : (m_mode == 2) ? (k % 2 == 1) : 1'b0;
        ph   = inv ? (m_per - m_cnt) : m_cnt;
        car  = (k - 2) * m_per + ph;
        g[k] = (r > car);
        ones += int'(g[k]);
      end
      exp_gate = g;
      exp_lvl  = ones - 2;
      if (m_up && m_cnt >= m_per) begin nc = m_cnt - 1; m_up = 0; end
      else if (m_up) nc = m_cnt + 1;
      else nc = m_cnt - 1;
      if (nc == 0) begin
        m_up   = 1;
        m_mode = int'(mode_i);
        m_per  = (period_i == 0) ? 1 : int'(period_i);
      end
      m_cnt = nc;
    end
  end

  task automatic cmp(string tag);
    checks++;
    if (gate_o !== exp_gate) begin
      errs++;
      $display("FAIL %s gate_o act=%b exp=%b", tag, gate_o, exp_gate);
    end
    checks++;
    if (int'($signed(level_o)) != exp_lvl) begin
      errs++;
      $display("FAIL %s level_o act=%0d exp=%0d", tag, $signed(level_o), exp_lvl);
    end
  endtask

  task automatic chk_gate(string tag, logic [3:0] exp);
    checks++;
    if (gate_o !== exp) begin
      errs++;
      $display("FAIL %s gate_o act=%b exp=%b", tag, gate_o, exp);
    end
  endtask

  task automatic sweep(string tag, int n, int amp, int step);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp(tag);
      ref_i = 12'(-amp + (i * step) % (2 * amp + 1));
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ref_i = '0; mode_i = 2'd0; period_i = 8'(DEF);
    repeat (3) @(negedge clk);
    chk_gate("R1 in reset", 4'b0000);
    cmp("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 first cycle");
    sweep("R1 default period", 60, 45, 7);
  endtask

  task automatic t_mode(string tag, logic [1:0] m, int per, int amp);
    mode_i = m; period_i = 8'(per);
    sweep(tag, 8 * per + 60, amp, 5);
  endtask

  task automatic t_latency();
    mode_i = 2'd0; period_i = 8'd4;
    ref_i = 12'(-2048);
    sweep("R4 settle", 20, 8, 3);
    ref_i = 12'(-2048);
    repeat (2) @(negedge clk);
    chk_gate("R10 low sat", 4'b0000);
    ref_i = 12'(2047);
    #1 chk_gate("R4 before edge", 4'b0000);
    @(negedge clk);
    chk_gate("R4 after one edge", 4'b1111);
    @(negedge clk);
    chk_gate("R10 high sat", 4'b1111);
    cmp("R10 high sat");
    ref_i = 12'(-8);
    @(negedge clk);
    chk_gate("R10 at -2P", 4'b0000);
    cmp("R10 at -2P");
  endtask

  task automatic t_mode_hop();
    period_i = 8'd6;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      cmp("R9 mode hop");
      if (i % 3 == 0) mode_i = 2'((i / 3) % 3);
      ref_i = 12'((i * 5) % 25 - 12);
    end
  endtask

  task automatic t_period();
    mode_i = 2'd0;
    period_i = 8'd0;
    sweep("R2 zero period", 40, 3, 1);
    period_i = 8'd5;
    sweep("R2 short period", 60, 11, 3);
    period_i = 8'd255;
    mode_i = 2'd2;
    sweep("R2 long period", 1200, 520, 37);
    period_i = 8'd3;
    sweep("R2 shrink", 1100, 7, 2);
  endtask

  initial begin
    #2000000;
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_mode("R5 R3 in-phase", 2'd0, 20, 45);
    t_mode("R6 R3 lower inverted", 2'd1, 20, 45);
    t_mode("R7 R3 alternating", 2'd2, 20, 45);
    t_mode("R5 spare code", 2'd3, 10, 23);
    t_mode("R7 R8 small period", 2'd2, 2, 5);
    t_latency();
    t_mode_hop();
    t_period();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule